// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block models the moment a processor core enters a general or a debug exception. The core presents the program counter of the faulting instruction, a cause code and, for address faults, the faulting virtual address, together with a one-cycle request strobe. The block decides which handler class applies, records the machine state that the handler needs, updates the processor-status word and issues a one-cycle redirect carrying the handler's fetch address.

A general exception taken while the status word already shows exception mode is promoted to a double exception. That path has its own vector and, when configured, its own save register, so the first handler's saved PC is kept. A debug request is honoured only when the current interrupt level lies strictly below the configured debug level. Taking it raises the interrupt level to the debug level. Every handler address can be moved through a vector-base register: the default address is rebased from the reset-time base to the current one.

The status word and the vector base can also be loaded by the core, for example when a handler returns or the core switches into user mode. Decode, register windows and the memory system lie outside this block.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, the status word `ps_o` is zero, `vecbase_o` equals the reset vector base (0x0000_0000), every save register reads zero and `redirect_vld_o` is low.
- R2: On a general request (`exc_req_i`) while the exception-mode bit (`ps_o` bit ILVL_W) is clear, `exc_pc_i` is written into `epc1_o`. The handler is the user vector (0x340) when the user-mode bit (`ps_o` bit ILVL_W+1) is set, and the kernel vector (0x300) when it is clear.
- R3: On a general request while the exception-mode bit is set, the handler is the double vector (0x3C0). With HAS_DEPC=1 the PC goes into `depc_o` and `epc1_o` keeps its value. With HAS_DEPC=0 the PC goes into `epc1_o`.
- R4: Every general exception writes `exc_cause_i` into `exccause_o` and sets the exception-mode bit. The user-mode bit and the interrupt level are left unchanged.
- R5: `excvaddr_o` takes `exc_vaddr_i` only when `exc_vaddr_vld_i` is high together with `exc_req_i`. Otherwise it keeps its value.
- R6: A debug request (`dbg_req_i`) is taken only when `exc_req_i` is low and the interrupt level (`ps_o` bits ILVL_W-1:0) is strictly below DEBUG_LEVEL (default 6). A request that is not taken changes no debug register and gives no redirect.
- R7: A debug entry writes `dbg_cause_i` into `dbgcause_o`, the PC into `epc_dbg_o` and the old status word into `eps_dbg_o`. It then sets the interrupt level to DEBUG_LEVEL and sets the exception-mode bit, leaving the user-mode bit unchanged. The handler is the debug vector (0x280).
- R8: With RELOC_EN=1 the redirect address is the default vector minus the reset vector base plus the vector base held before the request's clock edge, modulo 2^32.
- R9: `redirect_vld_o` is high for exactly the cycle after each accepted request, with `redirect_pc_o` valid in that cycle. It is low after any cycle that has no accepted request.
- R10: `ps_wr_i` loads `ps_wdata_i` ({user, exception-mode, level}) into the status word on the next edge, unless an exception is taken on that edge; in that case the load is ignored. `vecbase_wr_i` always loads `vecbase_wdata_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req_i | input | 1 | General exception request strobe |
| exc_pc_i | input | 32 | PC of the faulting instruction (also used for debug) |
| exc_cause_i | input | CAUSE_W | General exception cause code |
| exc_vaddr_vld_i | input | 1 | Request carries a faulting virtual address |
| exc_vaddr_i | input | 32 | Faulting virtual address |
| dbg_req_i | input | 1 | Debug exception request strobe |
| dbg_cause_i | input | DCAUSE_W | Debug cause code |
| ps_wr_i | input | 1 | Load the status word |
| ps_wdata_i | input | ILVL_W+2 | New status word {user, exception-mode, level} |
| vecbase_wr_i | input | 1 | Load the vector base |
| vecbase_wdata_i | input | 32 | New vector base |
| redirect_vld_o | output | 1 | One-cycle fetch redirect pulse |
| redirect_pc_o | output | 32 | Handler fetch address |
| ps_o | output | ILVL_W+2 | Status word {user, exception-mode, level} |
| vecbase_o | output | 32 | Current vector base |
| epc1_o | output | 32 | Level-1 saved PC |
| depc_o | output | 32 | Double-exception saved PC |
| exccause_o | output | CAUSE_W | Last general cause |
| excvaddr_o | output | 32 | Last faulting virtual address |
| dbgcause_o | output | DCAUSE_W | Last debug cause |
| epc_dbg_o | output | 32 | Saved PC for the debug level |
| eps_dbg_o | output | ILVL_W+2 | Saved status word for the debug level |

## Verification
The assertions assume that the core never needs a general and a debug request in the same cycle to be honoured together. They also assume that the status word, including a level of DEBUG_LEVEL or above, may be loaded at any time the core chooses. The stimulus draws every strobe, status word and vector base at random with a fixed seed, so simultaneous requests, loads that collide with requests and levels on both sides of the debug gate all occur. Directed steps first pin down the kernel, user, double and gated-debug boundaries before the random phase begins.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int ADDR_W = 32;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [2:0] {
    CLS_NONE, CLS_KERNEL, CLS_USER, CLS_DOUBLE, CLS_DEBUG
  } exc_cls_e;

  // Move a default handler address from the reset-time base to the live base.
  function automatic addr_t rebase_vec(addr_t dflt, addr_t rst_base, addr_t cur_base, bit en);
    return en ? (dflt - rst_base + cur_base) : dflt;
  endfunction
endpackage

// File: rtl/exc_class_sel.sv
module exc_class_sel
  import exc_entry_pkg::*;
#(
  parameter int ILVL_W      = 4,
  parameter int DEBUG_LEVEL = 6
) (
  input  logic              exc_req,
  input  logic              dbg_req,
  input  logic              excm,
  input  logic              um,
  input  logic [ILVL_W-1:0] ilvl,
  output logic              take_exc,
  output logic              take_dbg,
  output exc_cls_e          cls
);
  localparam logic [ILVL_W-1:0] DBG_LVL = ILVL_W'(DEBUG_LEVEL);

  logic dbg_open;
  assign dbg_open = (ilvl < DBG_LVL);
  assign take_exc = exc_req;
  assign take_dbg = dbg_req && !exc_req && dbg_open;

  always_comb begin
    cls = CLS_NONE;
    if (take_exc) begin
      if (excm)    cls = CLS_DOUBLE;
      else if (um) cls = CLS_USER;
      else         cls = CLS_KERNEL;
    end else if (take_dbg) begin
      cls = CLS_DEBUG;
    end
  end
endmodule

// File: rtl/exc_vec_reloc.sv
module exc_vec_reloc
  import exc_entry_pkg::*;
#(
  parameter bit    RELOC_EN   = 1'b1,
  parameter addr_t RST_VB     = 32'h0000_0000,
  parameter addr_t VEC_KERNEL = 32'h0000_0300,
  parameter addr_t VEC_USER   = 32'h0000_0340,
  parameter addr_t VEC_DOUBLE = 32'h0000_03C0,
  parameter addr_t VEC_DEBUG  = 32'h0000_0280
) (
  input  exc_cls_e cls,
  input  addr_t    vecbase,
  output addr_t    target
);
  addr_t dflt;

  always_comb begin
    case (cls)
      CLS_USER:   dflt = VEC_USER;
      CLS_DOUBLE: dflt = VEC_DOUBLE;
      CLS_DEBUG:  dflt = VEC_DEBUG;
      default:    dflt = VEC_KERNEL;
    endcase
  end

  generate
    if (RELOC_EN) begin : g_reloc
      assign target = rebase_vec(dflt, RST_VB, vecbase, 1'b1);
    end else begin : g_fixed
      addr_t unused_vb;
      assign unused_vb = vecbase;
      assign target = dflt;
    end
  endgenerate
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_entry_pkg::*;
#(
  parameter int    ILVL_W      = 4,
  parameter int    CAUSE_W     = 6,
  parameter int    DCAUSE_W    = 6,
  parameter int    DEBUG_LEVEL = 6,
  parameter bit    HAS_DEPC    = 1'b1,
  parameter addr_t RST_VB      = 32'h0000_0000,
  localparam int   PS_W        = ILVL_W + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take_exc,
  input  logic                take_dbg,
  input  addr_t               pc,
  input  logic [CAUSE_W-1:0]  cause,
  input  logic                vaddr_vld,
  input  addr_t               vaddr,
  input  logic [DCAUSE_W-1:0] dcause,
  input  logic                ps_wr,
  input  logic [PS_W-1:0]     ps_wdata,
  input  logic                vb_wr,
  input  addr_t               vb_wdata,
  input  addr_t               target,
  output logic                redirect_vld,
  output addr_t               redirect_pc,
  output logic [PS_W-1:0]     ps,
  output addr_t               vecbase,
  output addr_t               epc1,
  output addr_t               depc,
  output logic [CAUSE_W-1:0]  exccause,
  output addr_t               excvaddr,
  output logic [DCAUSE_W-1:0] dbgcause,
  output addr_t               epc_dbg,
  output logic [PS_W-1:0]     eps_dbg
);
  localparam int EXCM_B = ILVL_W;
  localparam logic [ILVL_W-1:0] DBG_LVL = ILVL_W'(DEBUG_LEVEL);

  logic nested;
  assign nested = ps[EXCM_B];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps <= '0; epc1 <= '0; exccause <= '0; excvaddr <= '0;
      dbgcause <= '0; epc_dbg <= '0; eps_dbg <= '0;
      redirect_vld <= 1'b0; redirect_pc <= '0;
    end else begin
      redirect_vld <= take_exc || take_dbg;
      if (take_exc || take_dbg) redirect_pc <= target;
      if (take_exc) begin
        exccause   <= cause;
        ps[EXCM_B] <= 1'b1;
        if (vaddr_vld) excvaddr <= vaddr;
        if (!nested || !HAS_DEPC) epc1 <= pc;
      end else if (take_dbg) begin
        dbgcause           <= dcause;
        epc_dbg            <= pc;
        eps_dbg            <= ps;
        ps[ILVL_W-1:0]     <= DBG_LVL;
        ps[EXCM_B]         <= 1'b1;
      end else if (ps_wr) begin
        ps <= ps_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     vecbase <= RST_VB;
    else if (vb_wr) vecbase <= vb_wdata;
  end

  generate
    if (HAS_DEPC) begin : g_depc
      always_ff @(posedge clk) begin
        if (!rst_n)                 depc <= '0;
        else if (take_exc && nested) depc <= pc;
      end
    end else begin : g_no_depc
      assign depc = '0;
    end
  endgenerate

  // R3: with a dedicated register, a nested entry leaves the first saved PC alone
  a_r3_epc1_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_DEPC && take_exc && nested) |=> $stable(epc1));
  // R5: no address strobe, no address update
  a_r5_vaddr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_exc && vaddr_vld) |=> $stable(excvaddr));
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int    ILVL_W      = 4,
  parameter int    CAUSE_W     = 6,
  parameter int    DCAUSE_W    = 6,
  parameter int    DEBUG_LEVEL = 6,
  parameter bit    HAS_DEPC    = 1'b1,
  parameter bit    RELOC_EN    = 1'b1,
  parameter addr_t RST_VB      = 32'h0000_0000,
  parameter addr_t VEC_KERNEL  = 32'h0000_0300,
  parameter addr_t VEC_USER    = 32'h0000_0340,
  parameter addr_t VEC_DOUBLE  = 32'h0000_03C0,
  parameter addr_t VEC_DEBUG   = 32'h0000_0280,
  localparam int   PS_W        = ILVL_W + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                exc_req_i,
  input  logic [31:0]         exc_pc_i,
  input  logic [CAUSE_W-1:0]  exc_cause_i,
  input  logic                exc_vaddr_vld_i,
  input  logic [31:0]         exc_vaddr_i,
  input  logic                dbg_req_i,
  input  logic [DCAUSE_W-1:0] dbg_cause_i,
  input  logic                ps_wr_i,
  input  logic [PS_W-1:0]     ps_wdata_i,
  input  logic                vecbase_wr_i,
  input  logic [31:0]         vecbase_wdata_i,
  output logic                redirect_vld_o,
  output logic [31:0]         redirect_pc_o,
  output logic [PS_W-1:0]     ps_o,
  output logic [31:0]         vecbase_o,
  output logic [31:0]         epc1_o,
  output logic [31:0]         depc_o,
  output logic [CAUSE_W-1:0]  exccause_o,
  output logic [31:0]         excvaddr_o,
  output logic [DCAUSE_W-1:0] dbgcause_o,
  output logic [31:0]         epc_dbg_o,
  output logic [PS_W-1:0]     eps_dbg_o
);
  localparam int EXCM_B = ILVL_W;
  localparam int UM_B   = ILVL_W + 1;
  localparam logic [ILVL_W-1:0] DBG_LVL = ILVL_W'(DEBUG_LEVEL);

  // Named internal events
  logic     take_exc, take_dbg;
  exc_cls_e cls;
  addr_t    target;

  exc_class_sel #(.ILVL_W(ILVL_W), .DEBUG_LEVEL(DEBUG_LEVEL)) u_sel (
    .exc_req(exc_req_i), .dbg_req(dbg_req_i),
    .excm(ps_o[EXCM_B]), .um(ps_o[UM_B]), .ilvl(ps_o[ILVL_W-1:0]),
    .take_exc(take_exc), .take_dbg(take_dbg), .cls(cls));

  exc_vec_reloc #(.RELOC_EN(RELOC_EN), .RST_VB(RST_VB), .VEC_KERNEL(VEC_KERNEL),
    .VEC_USER(VEC_USER), .VEC_DOUBLE(VEC_DOUBLE), .VEC_DEBUG(VEC_DEBUG)) u_reloc (
    .cls(cls), .vecbase(vecbase_o), .target(target));

  exc_state_regs #(.ILVL_W(ILVL_W), .CAUSE_W(CAUSE_W), .DCAUSE_W(DCAUSE_W),
    .DEBUG_LEVEL(DEBUG_LEVEL), .HAS_DEPC(HAS_DEPC), .RST_VB(RST_VB)) u_regs (
    .clk(clk), .rst_n(rst_n), .take_exc(take_exc), .take_dbg(take_dbg),
    .pc(exc_pc_i), .cause(exc_cause_i), .vaddr_vld(exc_vaddr_vld_i),
    .vaddr(exc_vaddr_i), .dcause(dbg_cause_i), .ps_wr(ps_wr_i),
    .ps_wdata(ps_wdata_i), .vb_wr(vecbase_wr_i), .vb_wdata(vecbase_wdata_i),
    .target(target), .redirect_vld(redirect_vld_o), .redirect_pc(redirect_pc_o),
    .ps(ps_o), .vecbase(vecbase_o), .epc1(epc1_o), .depc(depc_o),
    .exccause(exccause_o), .excvaddr(excvaddr_o), .dbgcause(dbgcause_o),
    .epc_dbg(epc_dbg_o), .eps_dbg(eps_dbg_o));

  // R3: nested general entry lands on the rebased double vector
  a_r3_double_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req_i && ps_o[EXCM_B]) |=>
      (redirect_vld_o && redirect_pc_o == rebase_vec(VEC_DOUBLE, RST_VB, $past(vecbase_o), RELOC_EN)));
  // R4: general entry sets exception mode and keeps user bit and level
  a_r4_excm_set: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req_i |=> (ps_o[EXCM_B] && ps_o[UM_B] == $past(ps_o[UM_B]) &&
                   ps_o[ILVL_W-1:0] == $past(ps_o[ILVL_W-1:0])));
  // R6: gated debug request leaves no trace
  a_r6_dbg_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req_i && !exc_req_i && ps_o[ILVL_W-1:0] >= DBG_LVL) |=>
      (!redirect_vld_o && $stable(dbgcause_o) && $stable(epc_dbg_o)));
  // R7: debug entry raises level to the debug level
  a_r7_dbg_level: assert property (@(posedge clk) disable iff (!rst_n)
    take_dbg |=> (ps_o[ILVL_W-1:0] == DBG_LVL && ps_o[EXCM_B] && eps_dbg_o == $past(ps_o)));
  // R9: no redirect without a request in the previous cycle
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_req_i && !dbg_req_i) |=> !redirect_vld_o);
  a_r9_one_hot_take: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_exc, take_dbg}));
endmodule

// File: tb/exc_entry_ctrl_tb_top.sv
module exc_entry_ctrl_tb_top;
  localparam int ILVL_W = 4, CW = 6, DW = 6, DBGL = 6, PSW = ILVL_W + 2;
  localparam logic [31:0] RSTVB = 32'h0, VK = 32'h300, VU = 32'h340, VD = 32'h3C0, VG = 32'h280;

  logic clk = 0, rst_n = 0;
  logic exc_req = 0, vaddr_vld = 0, dbg_req = 0, ps_wr = 0, vb_wr = 0;
  logic [31:0] pc = 0, vaddr = 0, vb_wdata = 0;
  logic [CW-1:0] cause = 0;
  logic [DW-1:0] dcause = 0;
  logic [PSW-1:0] ps_wdata = 0;
  logic rv; logic [31:0] rpc, vb, epc1, depc, xva, epcd;
  logic [PSW-1:0] ps, epsd; logic [CW-1:0] xc; logic [DW-1:0] dc;

  int n_chk = 0, n_fail = 0;
  // bench model
  logic m_rv; logic [31:0] m_rpc, m_vb, m_epc1, m_depc, m_xva, m_epcd;
  logic [PSW-1:0] m_ps, m_epsd; logic [CW-1:0] m_xc; logic [DW-1:0] m_dc;

  always #10 clk = ~clk;

  exc_entry_ctrl dut_i (.clk(clk), .rst_n(rst_n), .exc_req_i(exc_req), .exc_pc_i(pc),
    .exc_cause_i(cause), .exc_vaddr_vld_i(vaddr_vld), .exc_vaddr_i(vaddr),
    .dbg_req_i(dbg_req), .dbg_cause_i(dcause), .ps_wr_i(ps_wr), .ps_wdata_i(ps_wdata),
    .vecbase_wr_i(vb_wr), .vecbase_wdata_i(vb_wdata), .redirect_vld_o(rv),
    .redirect_pc_o(rpc), .ps_o(ps), .vecbase_o(vb), .epc1_o(epc1), .depc_o(depc),
    .exccause_o(xc), .excvaddr_o(xva), .dbgcause_o(dc), .epc_dbg_o(epcd), .eps_dbg_o(epsd));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] handler(logic [31:0] base_vec);
    return base_vec + (m_vb - RSTVB);   // R8 rebasing
  endfunction

  // Expected next state from the requirements, using inputs before the edge
  task automatic model_edge();
    logic gexc, gdbg;
    gexc = exc_req;
    gdbg = dbg_req && !exc_req && (m_ps[ILVL_W-1:0] < DBGL);
    m_rv = gexc || gdbg;
    if (gexc) begin
      if (m_ps[ILVL_W]) begin m_rpc = handler(VD); m_depc = pc; end
      else begin m_rpc = handler(m_ps[ILVL_W+1] ? VU : VK); m_epc1 = pc; end
      m_xc = cause;
      if (vaddr_vld) m_xva = vaddr;
      m_ps[ILVL_W] = 1'b1;
    end else if (gdbg) begin
      m_rpc = handler(VG);
      m_dc = dcause; m_epcd = pc; m_epsd = m_ps;
      m_ps = {m_ps[ILVL_W+1], 1'b1, 4'(DBGL)};
    end else if (ps_wr) m_ps = ps_wdata;
    if (vb_wr) m_vb = vb_wdata;
  endtask

  task automatic compare_all();
    chk("R9 redirect_vld", 32'(rv), 32'(m_rv));
    if (m_rv) chk("R8 redirect_pc", rpc, m_rpc);
    chk("R4/R7/R10 ps", 32'(ps), 32'(m_ps));
    chk("R10 vecbase", vb, m_vb);
    chk("R2 epc1", epc1, m_epc1);
    chk("R3 depc", depc, m_depc);
    chk("R4 exccause", 32'(xc), 32'(m_xc));
    chk("R5 excvaddr", xva, m_xva);
    chk("R7 dbgcause", 32'(dc), 32'(m_dc));
    chk("R7 epc_dbg", epcd, m_epcd);
    chk("R7 eps_dbg", 32'(epsd), 32'(m_epsd));
  endtask

  task automatic step();
    model_edge();
    @(posedge clk); @(negedge clk);
    compare_all();
    exc_req = 0; dbg_req = 0; ps_wr = 0; vb_wr = 0; vaddr_vld = 0;
  endtask

  task automatic gen_exc(logic [31:0] p, logic [CW-1:0] c);
    exc_req = 1; pc = p; cause = c; step();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    m_rv = 0; m_rpc = 0; m_vb = RSTVB; m_epc1 = 0; m_depc = 0; m_xva = 0;
    m_epcd = 0; m_ps = 0; m_epsd = 0; m_xc = 0; m_dc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    chk("R1 ps", 32'(ps), 0); chk("R1 vecbase", vb, RSTVB);
    chk("R1 redirect_vld", 32'(rv), 0); chk("R1 epc1", epc1, 0); chk("R1 depc", depc, 0);
    // R2 kernel entry
    gen_exc(32'h1000, 6'd3);
    chk("R2 kernel vector", rpc, VK);
    step();                                       // R9 pulse ends
    chk("R9 pulse low", 32'(rv), 0);
    // R3 nested -> double, epc1 kept
    vaddr_vld = 1; vaddr = 32'hDEAD_0000;
    gen_exc(32'h2000, 6'd9);
    chk("R3 double vector", rpc, VD); chk("R3 epc1 kept", epc1, 32'h1000);
    chk("R5 vaddr taken", xva, 32'hDEAD_0000);
    // R10 load user mode, level 0; R2 user vector with relocated base
    ps_wr = 1; ps_wdata = {1'b1, 1'b0, 4'd0}; vb_wr = 1; vb_wdata = 32'h4000_0000; step();
    gen_exc(32'h3000, 6'd1);
    chk("R8 user vector rebased", rpc, 32'h4000_0340);
    // R6 boundary: level == DEBUG_LEVEL gated
    ps_wr = 1; ps_wdata = {1'b0, 1'b0, 4'd6}; step();
    dbg_req = 1; dcause = 6'd5; pc = 32'h5000; step();
    chk("R6 gated no redirect", 32'(rv), 0);
    // R7 level 5 taken
    ps_wr = 1; ps_wdata = {1'b1, 1'b0, 4'd5}; step();
    dbg_req = 1; dcause = 6'd7; pc = 32'h6000; step();
    chk("R7 debug vector", rpc, 32'h4000_0280);
    chk("R7 level", 32'(ps), 32'({1'b1, 1'b1, 4'd6}));
    // R6 simultaneous: general wins; R10 ps load ignored
    ps_wr = 1; ps_wdata = 0; step();
    exc_req = 1; dbg_req = 1; ps_wr = 1; ps_wdata = {1'b1, 1'b0, 4'd2}; pc = 32'h7000; step();
    chk("R6 general wins", rpc, 32'h4000_0300);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      exc_req   = ($urandom % 10) < 4;
      dbg_req   = ($urandom % 10) < 3;
      ps_wr     = ($urandom % 10) < 3;
      vb_wr     = ($urandom % 10) == 0;
      vaddr_vld = $urandom % 2;
      pc = $urandom; vaddr = $urandom; vb_wdata = $urandom;
      cause = CW'($urandom); dcause = DW'($urandom); ps_wdata = PSW'($urandom);
      step();
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule